// File: doc/BRIEF.md
# Falling-Edge Scanline Interrupt Counter

This block raises a scanline interrupt for cartridge boards whose picture-bus address line A12 reaches the counter without any low-time filter. It samples A12 in the system clock domain and treats each high-to-low transition as a candidate counter clock. Each line carries eight sprite pattern fetches, and each fetch pulses A12. An ignore window therefore counts eight falling edges and lets only the first one of each group clock the scanline counter, so the counter advances once per line.

Software controls the block through four write-only registers selected by a 2-bit code: a latch value, a reload request, an interrupt disable/acknowledge and an interrupt enable. A reload request also restarts the ignore window, so the next falling edge is always a counting one. The interrupt output is a registered level. Once set, it stays high until the disable register is written.

Top module: `a12_edge_irq`

## Requirements
- R1: After synchronous reset, irq_o is low, interrupts are disabled, the counter and the latch hold zero, and the ignore window is at its start.
- R2: A write with reg_sel = 0 stores wr_data as the latch value.
- R3: A write with reg_sel = 1 clears the counter, marks a reload as pending and restarts the ignore window, so the next falling edge of A12 counts.
- R4: A write with reg_sel = 2 disables the interrupt and clears irq_o on the following clock edge.
- R5: A write with reg_sel = 3 enables the interrupt. It leaves irq_o and the counter unchanged.
- R6: Only high-to-low transitions of a12_i are seen. A rising edge or a steady level, however long, causes no counter clock.
- R7: After a counting falling edge, the next seven falling edges are ignored. The eighth falling edge after it counts again, because the 3-bit window wraps.
- R8: On a counting edge, the counter loads the latch value if it is zero or a reload is pending. Otherwise it decrements by one.
- R9: If the counter is zero after a counting edge and the interrupt is enabled, irq_o goes high on the third rising clock edge after a12_i falls. It stays high until a disable write.
- R10: With a latch value of zero and the interrupt enabled, every counting edge sets irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a12_i | input | 1 | Picture-bus address line A12, asynchronous |
| reg_wr | input | 1 | Register write strobe, one clock wide |
| reg_sel | input | 2 | Register select: 0 latch, 1 reload, 2 disable/acknowledge, 3 enable |
| wr_data | input | 8 | Write data, used by the latch register |
| irq_o | output | 1 | Interrupt request, active high, level |

## Verification
A wrong ignore count or counter value cannot be seen directly at the ports. It shows up as an interrupt that comes a whole line early or late, which means eight A12 pulses away from the expected one. The bench therefore compares irq_o after every single falling edge against a model, so the fault appears at the first edge where the two differ. A wrong pipeline depth shows up as an interrupt one clock early or late relative to the falling edge, so the latency is also checked on an exact cycle.

// File: rtl/a12irq_pkg.sv
package a12irq_pkg;

    typedef enum logic [1:0] {
        SEL_LATCH   = 2'd0,
        SEL_RELOAD  = 2'd1,
        SEL_DISABLE = 2'd2,
        SEL_ENABLE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic latch_wr;
        logic reload_wr;
        logic irq_off;
        logic irq_on;
    } reg_cmd_t;

    function automatic reg_cmd_t decode_cmd(input logic wr, input logic [1:0] sel);
        reg_cmd_t c;
        c.latch_wr  = wr && (reg_sel_e'(sel) == SEL_LATCH);
        c.reload_wr = wr && (reg_sel_e'(sel) == SEL_RELOAD);
        c.irq_off   = wr && (reg_sel_e'(sel) == SEL_DISABLE);
        c.irq_on    = wr && (reg_sel_e'(sel) == SEL_ENABLE);
        return c;
    endfunction

endpackage

// File: rtl/a12irq_fall_det.sv
module a12irq_fall_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic a12_i,
    output logic fall_o
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[PIPE_W-2:0], a12_i};
    end

    // oldest sample high, next younger sample low: a high-to-low transition
    assign fall_o = pipe_q[PIPE_W-1] & ~pipe_q[PIPE_W-2];

    AST_NO_BACK_TO_BACK_FALL: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o); // R6

endmodule

// File: rtl/a12irq_ignore.sv
module a12irq_ignore #(
    parameter int IGN_BITS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic fall_i,
    input  logic clr_i,
    output logic count_en_o
);
    logic [IGN_BITS-1:0] ign_q;

    assign count_en_o = fall_i && (ign_q == '0);

    always_ff @(posedge clk) begin
        if (rst)         ign_q <= '0;
        else if (clr_i)  ign_q <= '0;
        else if (fall_i) ign_q <= ign_q + 1'b1;
    end

    AST_WINDOW_OPENS: assert property (@(posedge clk) disable iff (rst)
        (count_en_o && !clr_i) |=> (ign_q == IGN_BITS'(1))); // R7

    AST_CLR_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (ign_q == '0)); // R3

endmodule

// File: rtl/a12irq_counter.sv
module a12irq_counter
    import a12irq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             count_en_i,
    input  reg_cmd_t         cmd_i,
    input  logic [CNT_W-1:0] data_i,
    output logic             irq_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] latch_q;
    logic             pend_q;
    logic             en_q;
    logic [CNT_W-1:0] cnt_next;

    always_comb begin
        if (cnt_q == '0 || pend_q) cnt_next = latch_q;
        else                       cnt_next = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            latch_q <= '0;
            pend_q  <= 1'b0;
            en_q    <= 1'b0;
            irq_o   <= 1'b0;
        end else begin
            if (cmd_i.latch_wr) latch_q <= data_i;
            if (cmd_i.reload_wr) begin
                cnt_q  <= '0;
                pend_q <= 1'b1;
            end else if (count_en_i) begin
                cnt_q  <= cnt_next;
                pend_q <= 1'b0;
            end
            if (cmd_i.irq_off) begin
                en_q  <= 1'b0;
                irq_o <= 1'b0;
            end else begin
                if (cmd_i.irq_on) en_q <= 1'b1;
                if (count_en_i && !cmd_i.reload_wr && cnt_next == '0 && en_q)
                    irq_o <= 1'b1;
            end
        end
    end

    AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
        (count_en_i && !cmd_i.reload_wr && cnt_q != '0 && !pend_q)
        |=> (cnt_q == $past(cnt_q) - 1'b1)); // R8

    AST_RELOAD_TAKES_LATCH: assert property (@(posedge clk) disable iff (rst)
        (count_en_i && !cmd_i.reload_wr && !cmd_i.latch_wr && pend_q)
        |=> (cnt_q == latch_q)); // R8

endmodule

// File: rtl/a12_edge_irq.sv
module a12_edge_irq
    import a12irq_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int IGN_BITS    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             a12_i,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             irq_o
);
    logic     fall;
    logic     count_en;
    reg_cmd_t cmd;

    assign cmd = decode_cmd(reg_wr, reg_sel);

    a12irq_fall_det #(.SYNC_STAGES(SYNC_STAGES)) u_fall (
        .clk    (clk),
        .rst    (rst),
        .a12_i  (a12_i),
        .fall_o (fall)
    );

    a12irq_ignore #(.IGN_BITS(IGN_BITS)) u_ignore (
        .clk        (clk),
        .rst        (rst),
        .fall_i     (fall),
        .clr_i      (cmd.reload_wr),
        .count_en_o (count_en)
    );

    a12irq_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst        (rst),
        .count_en_i (count_en),
        .cmd_i      (cmd),
        .data_i     (wr_data),
        .irq_o      (irq_o)
    );

    AST_IRQ_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(count_en)); // R9

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cmd.irq_off |=> !irq_o); // R4

    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_o) |-> ($past(rst) || $past(cmd.irq_off))); // R9

endmodule

// File: tb/a12_edge_irq_bench.sv
module a12_edge_irq_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       a12 = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // reference model state
    int  m_cnt, m_latch, m_ign;
    bit  m_pend, m_en, m_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    a12_edge_irq u_a12_edge_irq (
        .clk(clk), .rst(rst), .a12_i(a12), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .wr_data(wr_data), .irq_o(irq)
    );

    function void model_reset();
        m_cnt = 0; m_latch = 0; m_ign = 0; m_pend = 0; m_en = 0; m_irq = 0;
    endfunction

    function void model_fall();
        if (m_ign == 0) begin
            if (m_cnt == 0 || m_pend) begin m_cnt = m_latch; m_pend = 0; end
            else m_cnt = m_cnt - 1;
            if (m_cnt == 0 && m_en) m_irq = 1;
        end
        m_ign = (m_ign + 1) % 8;
    endfunction

    function void model_write(int sel, int d);
        case (sel)
            0: m_latch = d;
            1: begin m_cnt = 0; m_pend = 1; m_ign = 0; end
            2: begin m_en = 0; m_irq = 0; end
            default: m_en = 1;
        endcase
    endfunction

    task automatic check(string req, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s irq_o actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wr(int sel, int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 2'(sel); wr_data = 8'(d);
        @(negedge clk);
        reg_wr = 1'b0;
        model_write(sel, d);
    endtask

    task automatic pulse();
        @(negedge clk); a12 = 1'b1;
        repeat (4) @(negedge clk);
        a12 = 1'b0;
        repeat (4) @(negedge clk);
        model_fall();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset", irq, 1'b0);

        // R1/R10: latch zero after reset, enable, first edge counts -> irq
        wr(3, 0);
        check("R5 enable alone", irq, 1'b0);
        pulse();
        check("R10 latch zero fires", irq, m_irq);
        wr(2, 0);
        check("R4 ack clears", irq, 1'b0);

        // R2/R3/R7: latch 1, reload, count edges through the window
        wr(0, 1);
        wr(1, 0);
        wr(3, 0);
        pulse(); // counting edge: loads 1
        check("R3 reload loads latch", irq, 1'b0);
        for (int i = 0; i < 7; i++) begin
            pulse();
            check("R7 ignored edge", irq, 1'b0);
        end
        pulse(); // 8th edge after counting one: 1 -> 0
        check("R7 eighth edge counts", irq, 1'b1);
        check("R8 model agrees", irq, m_irq);

        // R9: irq holds across further edges
        for (int i = 0; i < 8; i++) pulse();
        check("R9 irq holds", irq, 1'b1);
        wr(2, 0);

        // R6: long high level, no fall
        @(negedge clk); a12 = 1'b1;
        repeat (40) @(negedge clk);
        check("R6 rising/steady no effect", irq, m_irq);

        // R9 exact latency: latch 0, reload, enable, then drop a12
        wr(0, 0); wr(1, 0); wr(3, 0);
        @(negedge clk); a12 = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R9 not before third edge", irq, 1'b0);
        @(negedge clk);
        check("R9 on third edge", irq, 1'b1);
        model_fall();
        wr(2, 0);

        // R3: reload mid-window restarts it
        wr(0, 1); wr(1, 0); wr(3, 0);
        pulse(); pulse(); pulse(); // one counting, two ignored, cnt=1
        wr(1, 0);                  // window restart, pending reload
        pulse();                   // counts: reload -> 1
        check("R3 reload restarts window", irq, m_irq);
        for (int i = 0; i < 7; i++) pulse();
        pulse();
        check("R3 count after restart", irq, m_irq);

        // random mix
        process_seed();
        for (int k = 0; k < 600; k++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 7) pulse();
            else wr($urandom_range(0, 3), $urandom_range(0, 4));
            check("R8/R9 random", irq, m_irq);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    task automatic process_seed();
        void'($urandom(32'h5eed_a12f));
    endtask

endmodule